// File: doc/BRIEF.md
# Bipolar Line Decoder with Violation Flag

This block takes the positive and negative slicer outputs of one receive channel, one pair of bits per receive-clock cycle. It turns them back into NRZ data under one of three line codes. In AMI mode every mark maps to a one. In HDB3 mode the four-bit zero substitutions are recognised and removed. In B8ZS mode the eight-bit zero substitutions are recognised and removed. Marks that break the rules of the selected code raise a violation strobe that lines up with the affected data bit.

In single-rail operation the first output carries the decoded data and the second output carries the violation strobe. In dual-rail operation the two outputs carry the received positive and negative rails with the same latency. Configuration inputs can invert the data outputs and can move the output update to the falling clock edge. A separate combinational output gives the XOR of the two input rails, for use as a raw clock when clock recovery is done outside the block.

All symbols pass through an eight-stage window so that a B8ZS substitution can be removed once its last pulse has arrived. The latency is therefore the same in every mode.

Top module: `bipolar_line_decoder`

## Requirements
- R1: While `rst_n` is low, `dout_a` and `dout_b` are both 0.
- R2: `code_sel` selects the line code: 0 = AMI, 1 = HDB3, 2 = B8ZS, and 3 behaves as AMI. In single-rail mode with rising-edge update, a symbol sampled at clock edge k appears on `dout_a` after edge k+8. A mark (exactly one rail high) gives 1 and a space (both rails low) gives 0.
- R3: A mark with the same polarity as the previous single-rail mark is a bipolar violation. In AMI mode, `dout_b` is high for exactly the one cycle in which that mark's data bit is on `dout_a`.
- R4: In every code, a symbol with both rails high decodes as a mark and raises `dout_b`. It does not change the remembered polarity of the last mark.
- R5: With `edge_fall`=0 the outputs change just after the rising edge. With `edge_fall`=1 they keep their value across the rising edge and take the same value at the following falling edge.
- R6: With `dual_rail`=1, `dout_a` carries the positive rail and `dout_b` carries the negative rail, both with the latency of R2 and no decoding.
- R7: In B8ZS mode, consider a mark of polarity X that is itself a bipolar violation. If it has three spaces before it and is followed by -X, space, -X, X, the eight symbols decode as zeros and raise no violation. Every other bipolar violation raises `dout_b`.
- R8: In HDB3 mode, a bipolar violation preceded by two spaces, with either a space or a single mark before those, is a substitution. That bipolar violation and the mark before the two spaces decode as zeros. The substitution raises `dout_b` only if its polarity equals that of the previous substitution. A bipolar violation outside this pattern raises `dout_b`.
- R9: In HDB3 mode, every space that is the fourth or later in a run of consecutive spaces raises `dout_b`.
- R10: With `inv_data`=1 every data output is inverted: `dout_a` in single-rail mode, and both outputs in dual-rail mode. The violation strobe is never inverted.
- R11: `xor_clk` is the combinational XOR of `rail_p` and `rail_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_p | input | 1 | Positive pulse indication |
| rail_n | input | 1 | Negative pulse indication |
| code_sel | input | 2 | Line code: 0 AMI, 1 HDB3, 2 B8ZS, 3 AMI |
| dual_rail | input | 1 | 1 = output both rails, 0 = output data and violation |
| inv_data | input | 1 | Invert the data outputs |
| edge_fall | input | 1 | 1 = update the outputs on the falling edge |
| dout_a | output | 1 | Decoded data, or positive rail in dual-rail mode |
| dout_b | output | 1 | Violation strobe, or negative rail in dual-rail mode |
| xor_clk | output | 1 | XOR of the two input rails |

## Verification
The properties assume that `code_sel`, `dual_rail`, `inv_data` and `edge_fall` stay fixed while the block is out of reset. They also compare outputs against rail and event values nine rising edges earlier, so they only apply in rising-edge mode after a warm-up count. The stimulus changes configuration only while reset is held. It drives the rails at the falling edge, so every symbol is stable at the rising edge that samples it. Each scenario is followed by spaces that drain the eight-stage window.

// File: rtl/bpd_pkg.sv
package bpd_pkg;

  typedef enum logic [1:0] {
    CODE_AMI  = 2'd0,
    CODE_HDB3 = 2'd1,
    CODE_B8ZS = 2'd2,
    CODE_AMIX = 2'd3
  } code_e;

  // one received symbol with its decoded data and violation flag
  typedef struct packed {
    logic p;
    logic n;
    logic mark;
    logic viol;
  } sym_t;

  // window length needed by the longest substitution
  localparam int unsigned WIN_LEN = 8;
  // length of the short substitution
  localparam int unsigned SHORT_LEN = 4;

  function automatic logic is_space(input sym_t s);
    return !s.p && !s.n;
  endfunction

  function automatic logic is_single(input sym_t s);
    return s.p ^ s.n;
  endfunction

  function automatic logic same_pol(input sym_t a, input sym_t b);
    return is_single(a) && is_single(b) && (a.p == b.p);
  endfunction

  function automatic logic opp_pol(input sym_t a, input sym_t b);
    return is_single(a) && is_single(b) && (a.p != b.p);
  endfunction

endpackage

// File: rtl/bpd_classify.sv
module bpd_classify
  import bpd_pkg::*;
#(
  parameter int unsigned ZRUN_LIMIT = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rail_p,
  input  logic  rail_n,
  input  code_e code,
  input  logic  hdb_match,
  output logic  bpv_evt,
  output logic  both_evt,
  output logic  zrun_evt,
  output logic  vrep_evt,
  output sym_t  new_sym
);
  localparam int unsigned ZW = $clog2(ZRUN_LIMIT + 1);

  logic          lp_valid, lp_pos;
  logic          lv_valid, lv_pos;
  logic [ZW-1:0] zcnt;
  logic          single, space;

  assign single   = rail_p ^ rail_n;
  assign space    = !rail_p && !rail_n;
  assign bpv_evt  = single && lp_valid && (lp_pos == rail_p);
  assign both_evt = rail_p && rail_n;
  assign zrun_evt = (code == CODE_HDB3) && space && (zcnt >= ZW'(ZRUN_LIMIT - 1));
  assign vrep_evt = hdb_match && lv_valid && (lv_pos == rail_p);

  always_comb begin
    new_sym.p    = rail_p;
    new_sym.n    = rail_n;
    new_sym.mark = rail_p | rail_n;
    if (code == CODE_HDB3)
      new_sym.viol = both_evt | zrun_evt | vrep_evt | (bpv_evt & ~hdb_match);
    else
      new_sym.viol = both_evt | bpv_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_valid <= 1'b0;
      lp_pos   <= 1'b0;
      lv_valid <= 1'b0;
      lv_pos   <= 1'b0;
      zcnt     <= '0;
    end else begin
      if (single) begin
        lp_valid <= 1'b1;
        lp_pos   <= rail_p;
      end
      if (hdb_match) begin
        lv_valid <= 1'b1;
        lv_pos   <= rail_p;
      end
      if (!space)
        zcnt <= '0;
      else if (zcnt < ZW'(ZRUN_LIMIT))
        zcnt <= zcnt + 1'b1;
    end
  end

endmodule

// File: rtl/bpd_subst_window.sv
module bpd_subst_window
  import bpd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  code_e code,
  input  logic  bpv_evt,
  input  sym_t  new_sym,
  output logic  hdb_match,
  output logic  b8_match,
  output sym_t  out_sym
);
  // first stage of the short pattern inside the window
  localparam int unsigned HB = WIN_LEN - SHORT_LEN + 1;
  // stages cleared by the long substitution (after the shift)
  localparam logic [WIN_LEN-1:0] B8_CLR = 8'b1101_1000;

  sym_t s   [WIN_LEN];
  sym_t nxt [WIN_LEN];

  assign b8_match = (code == CODE_B8ZS) &&
                    is_space(s[1]) && is_space(s[2]) && is_space(s[3]) &&
                    is_single(s[4]) && s[4].viol &&
                    opp_pol(s[5], s[4]) && is_space(s[6]) &&
                    same_pol(s[7], s[5]) && same_pol(new_sym, s[4]);

  assign hdb_match = (code == CODE_HDB3) && bpv_evt &&
                     is_space(s[HB+1]) && is_space(s[HB+2]) &&
                     (is_space(s[HB]) || is_single(s[HB]));

  always_comb begin
    for (int i = 0; i < WIN_LEN - 1; i++) nxt[i] = s[i+1];
    nxt[WIN_LEN-1] = new_sym;
    for (int i = 0; i < WIN_LEN; i++) begin
      if (b8_match && B8_CLR[i]) begin
        nxt[i].mark = 1'b0;
        nxt[i].viol = 1'b0;
      end
    end
    if (hdb_match) begin
      nxt[HB-1].mark      = 1'b0;
      nxt[WIN_LEN-1].mark = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_LEN; i++) s[i] <= '0;
    end else begin
      for (int i = 0; i < WIN_LEN; i++) s[i] <= nxt[i];
    end
  end

  assign out_sym = s[0];

endmodule

// File: rtl/bpd_out_stage.sv
module bpd_out_stage
  import bpd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic dual,
  input  logic inv,
  input  logic edge_fall,
  input  sym_t sym,
  output logic dout_a,
  output logic dout_b
);
  logic a_d, b_d, a_r, b_r, a_f, b_f;

  assign a_d = (dual ? sym.p : sym.mark) ^ inv;
  assign b_d = dual ? (sym.n ^ inv) : sym.viol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_r <= 1'b0;
      b_r <= 1'b0;
    end else begin
      a_r <= a_d;
      b_r <= b_d;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_f <= 1'b0;
      b_f <= 1'b0;
    end else begin
      a_f <= a_r;
      b_f <= b_r;
    end
  end

  assign dout_a = edge_fall ? a_f : a_r;
  assign dout_b = edge_fall ? b_f : b_r;

endmodule

// File: rtl/bipolar_line_decoder.sv
module bipolar_line_decoder
  import bpd_pkg::*;
#(
  parameter int unsigned ZRUN_LIMIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rail_p,
  input  logic       rail_n,
  input  logic [1:0] code_sel,
  input  logic       dual_rail,
  input  logic       inv_data,
  input  logic       edge_fall,
  output logic       dout_a,
  output logic       dout_b,
  output logic       xor_clk
);
  code_e code;
  logic  bpv_evt, both_evt, zrun_evt, vrep_evt;
  logic  hdb_match, b8_match;
  logic  line_err_evt;
  sym_t  new_sym, out_sym;

  assign code         = code_e'(code_sel);
  assign line_err_evt = bpv_evt | both_evt;
  assign xor_clk      = rail_p ^ rail_n;

  bpd_classify #(.ZRUN_LIMIT(ZRUN_LIMIT)) u_classify (
    .clk      (clk),
    .rst_n    (rst_n),
    .rail_p   (rail_p),
    .rail_n   (rail_n),
    .code     (code),
    .hdb_match(hdb_match),
    .bpv_evt  (bpv_evt),
    .both_evt (both_evt),
    .zrun_evt (zrun_evt),
    .vrep_evt (vrep_evt),
    .new_sym  (new_sym)
  );

  bpd_subst_window u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .code     (code),
    .bpv_evt  (bpv_evt),
    .new_sym  (new_sym),
    .hdb_match(hdb_match),
    .b8_match (b8_match),
    .out_sym  (out_sym)
  );

  bpd_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .dual     (dual_rail),
    .inv      (inv_data),
    .edge_fall(edge_fall),
    .sym      (out_sym),
    .dout_a   (dout_a),
    .dout_b   (dout_b)
  );

endmodule

// File: rtl/bpd_checker.sv
module bpd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rail_p,
  input logic       rail_n,
  input logic [1:0] code_sel,
  input logic       dual_rail,
  input logic       inv_data,
  input logic       edge_fall,
  input logic       dout_a,
  input logic       dout_b,
  input logic       line_err_evt,
  input logic       zrun_evt,
  input logic       b8_match
);
  logic [3:0] cyc;
  logic       warm, sr_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 4'hF) cyc <= cyc + 1'b1;
  end

  assign warm    = (cyc >= 4'd10);
  assign sr_rise = warm && !dual_rail && !edge_fall;

  p_dual_rails_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && dual_rail && !edge_fall) |->
      (dout_a == ($past(rail_p, 9) ^ inv_data)) && (dout_b == ($past(rail_n, 9) ^ inv_data)));

  p_ami_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rise && (code_sel == 2'd0 || code_sel == 2'd3)) |-> (dout_b == $past(line_err_evt, 9)));

  p_both_rails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rise && $past(rail_p && rail_n, 9)) |-> (dout_b && (dout_a == !inv_data)));

  p_zero_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rise && code_sel == 2'd1 && $past(zrun_evt, 9)) |-> dout_b);

  p_b8zs_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rise && code_sel == 2'd2 && $past(b8_match, 9)) |-> (!dout_b && (dout_a == inv_data)));

endmodule

bind bipolar_line_decoder bpd_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rail_p      (rail_p),
  .rail_n      (rail_n),
  .code_sel    (code_sel),
  .dual_rail   (dual_rail),
  .inv_data    (inv_data),
  .edge_fall   (edge_fall),
  .dout_a      (dout_a),
  .dout_b      (dout_b),
  .line_err_evt(line_err_evt),
  .zrun_evt    (zrun_evt),
  .b8_match    (b8_match)
);

// File: tb/bipolar_line_decoder_test.sv
module bipolar_line_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rail_p = 1'b0, rail_n = 1'b0;
  logic [1:0] code_sel = 2'd0;
  logic       dual_rail = 1'b0, inv_data = 1'b0, edge_fall = 1'b0;
  logic       dout_a, dout_b, xor_clk;

  always #10 clk = ~clk;  // 50 MHz

  bipolar_line_decoder uut (
    .clk(clk), .rst_n(rst_n), .rail_p(rail_p), .rail_n(rail_n),
    .code_sel(code_sel), .dual_rail(dual_rail), .inv_data(inv_data),
    .edge_fall(edge_fall), .dout_a(dout_a), .dout_b(dout_b), .xor_clk(xor_clk)
  );

  int    checks = 0, fails = 0;
  string cur_req = "R2";
  bit    finished = 0;

  task automatic chk(input bit ok, input string req, input logic [1:0] act, input logic [1:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  // ---------------- reference model: symbol queue with polarity codes
  // pol: 0 space, 1 positive, -1 negative, 2 both rails
  int   q_pol[$];
  int   q_mark[$];
  int   q_viol[$];
  int   lpol, lvpol, zc;
  logic exp_a = 1'b0, exp_b = 1'b0;

  task automatic model_reset();
    q_pol = {}; q_mark = {}; q_viol = {};
    for (int k = 0; k < 8; k++) begin
      q_pol.push_back(0); q_mark.push_back(0); q_viol.push_back(0);
    end
    lpol = 0; lvpol = 0; zc = 0;
    exp_a = 1'b0; exp_b = 1'b0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int op, om, ov, pol, viol;
      bit bpv, hm, b8;
      op = q_pol.pop_front(); om = q_mark.pop_front(); ov = q_viol.pop_front();
      if (dual_rail) begin
        exp_a = ((op == 1) || (op == 2)) ^ inv_data;
        exp_b = ((op == -1) || (op == 2)) ^ inv_data;
      end else begin
        exp_a = (om != 0) ^ inv_data;
        exp_b = (ov != 0);
      end
      pol = (rail_p && rail_n) ? 2 : rail_p ? 1 : rail_n ? -1 : 0;
      bpv = (pol == 1 || pol == -1) && (pol == lpol);
      hm  = (code_sel == 2'd1) && bpv && q_pol[5] == 0 && q_pol[6] == 0 && q_pol[4] != 2;
      b8  = (code_sel == 2'd2) && q_pol[0] == 0 && q_pol[1] == 0 && q_pol[2] == 0 &&
            (q_pol[3] == 1 || q_pol[3] == -1) && q_viol[3] != 0 &&
            q_pol[4] == -q_pol[3] && q_pol[5] == 0 && q_pol[6] == q_pol[4] && pol == q_pol[3];
      if (code_sel == 2'd1)
        viol = int'((pol == 2) || (pol == 0 && zc >= 3) || (hm && lvpol == pol) || (bpv && !hm));
      else
        viol = int'((pol == 2) || bpv);
      if (pol == 1 || pol == -1) lpol = pol;
      if (hm) lvpol = pol;
      zc = (pol == 0) ? zc + 1 : 0;
      q_pol.push_back(pol); q_mark.push_back(int'(pol != 0)); q_viol.push_back(viol);
      if (b8) begin
        q_mark[3] = 0; q_viol[3] = 0; q_mark[4] = 0; q_viol[4] = 0;
        q_mark[6] = 0; q_viol[6] = 0; q_mark[7] = 0; q_viol[7] = 0;
      end
      if (hm) begin
        q_mark[4] = 0; q_mark[7] = 0;
      end
    end
  end

  // ---------------- per-cycle comparison
  logic pa, pb;
  bit   pvalid = 0;
  always @(posedge clk) begin
    #5;
    if (rst_n && edge_fall && pvalid)
      chk({dout_a, dout_b} == {pa, pb}, "R5", {dout_a, dout_b}, {pa, pb});
    else if (rst_n && !edge_fall)
      chk({dout_a, dout_b} == {exp_a, exp_b}, cur_req, {dout_a, dout_b}, {exp_a, exp_b});
    #10;
    if (rst_n) begin
      chk({dout_a, dout_b} == {exp_a, exp_b}, cur_req, {dout_a, dout_b}, {exp_a, exp_b});
      pa = dout_a; pb = dout_b; pvalid = 1;
    end else pvalid = 0;
  end

  // ---------------- stimulus
  int tb_lp = 0;

  task automatic put(input int pol);
    @(negedge clk);
    rail_p = (pol == 1 || pol == 2);
    rail_n = (pol == -1 || pol == 2);
    if (pol == 1 || pol == -1) tb_lp = pol;
    #1 chk(xor_clk == (rail_p ^ rail_n), "R11", {1'b0, xor_clk}, {1'b0, rail_p ^ rail_n});
  endtask

  task automatic mark();
    put(tb_lp == 1 ? -1 : 1);
  endtask

  task automatic spaces(input int n);
    for (int i = 0; i < n; i++) put(0);
  endtask

  task automatic b8sub();
    int x;
    x = (tb_lp == 0) ? 1 : tb_lp;
    spaces(3); put(x); put(-x); put(0); put(-x); put(x);
  endtask

  task automatic hd_zzzv();
    spaces(3); put(tb_lp == 0 ? 1 : tb_lp);
  endtask

  task automatic hd_bzzv();
    int b;
    b = (tb_lp == 1) ? -1 : 1;
    put(b); spaces(2); put(b);
  endtask

  task automatic restart(input logic [1:0] c, input logic d, input logic i, input logic e);
    @(negedge clk);
    rst_n = 1'b0; rail_p = 1'b0; rail_n = 1'b0;
    code_sel = c; dual_rail = d; inv_data = i; edge_fall = e;
    tb_lp = 0;
    repeat (2) @(negedge clk);
    chk(dout_a == 1'b0 && dout_b == 1'b0, "R1", {dout_a, dout_b}, 2'b00);
    rst_n = 1'b1;
  endtask

  task automatic rand_run(input int n, input bit allow_both);
    for (int i = 0; i < n; i++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r < 4) put(0);
      else if (r < 8) mark();
      else if (r == 8) put(tb_lp == 0 ? 1 : tb_lp);
      else if (allow_both) put(2);
      else put(0);
    end
  endtask

  initial begin
    restart(2'd0, 1'b0, 1'b0, 1'b0);
    cur_req = "R2";
    mark(); put(0); mark(); mark(); spaces(3); mark(); spaces(10);
    cur_req = "R3";
    mark(); put(tb_lp); put(0); put(tb_lp); mark(); rand_run(60, 0); spaces(10);
    cur_req = "R4";
    mark(); put(2); mark(); put(2); put(2); rand_run(40, 1); spaces(10);

    restart(2'd3, 1'b0, 1'b0, 1'b0);
    cur_req = "R2";
    rand_run(40, 1); spaces(10);

    restart(2'd0, 1'b0, 1'b1, 1'b0);
    cur_req = "R10";
    rand_run(50, 1); spaces(10);

    restart(2'd0, 1'b1, 1'b0, 1'b0);
    cur_req = "R6";
    rand_run(40, 1); spaces(10);
    restart(2'd2, 1'b1, 1'b1, 1'b0);
    mark(); b8sub(); rand_run(30, 1); spaces(10);

    restart(2'd0, 1'b0, 1'b0, 1'b1);
    cur_req = "R5";
    rand_run(40, 1); spaces(10);
    restart(2'd1, 1'b1, 1'b1, 1'b1);
    rand_run(30, 1); spaces(10);

    restart(2'd2, 1'b0, 1'b0, 1'b0);
    cur_req = "R7";
    mark(); b8sub(); mark(); mark(); b8sub(); b8sub(); put(tb_lp); mark();
    spaces(2); b8sub(); put(0); put(tb_lp);
    for (int k = 0; k < 6; k++) begin rand_run(8, 1); mark(); b8sub(); end
    spaces(10);
    restart(2'd2, 1'b0, 1'b1, 1'b0);
    mark(); b8sub(); rand_run(30, 1); spaces(10);

    restart(2'd1, 1'b0, 1'b0, 1'b0);
    cur_req = "R8";
    mark(); hd_zzzv(); mark(); hd_bzzv(); hd_bzzv(); mark(); hd_zzzv(); hd_zzzv();
    put(tb_lp); mark(); put(0); put(tb_lp); mark(); spaces(2); put(2); spaces(2); put(tb_lp);
    for (int k = 0; k < 6; k++) begin rand_run(6, 1); mark(); hd_bzzv(); hd_zzzv(); end
    spaces(10);
    cur_req = "R9";
    mark(); spaces(7); mark(); spaces(4); mark(); spaces(3); mark(); rand_run(60, 1);
    spaces(12);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule